// File: doc/BRIEF.md
# Four-Bit Immediate-Add Accumulator CPU

This block is a small 4-bit processor core. Each clock it fetches one 8-bit instruction from a 16-word program ROM at the address held in a 4-bit program counter, and executes it in the same cycle. The core holds two working registers, a 4-bit output register and a carry flag. A 4-bit input port is sampled directly.

The core has no separate move path or ALU path. Every instruction picks one source (register A, register B, the input port or the constant zero), adds the instruction's immediate nibble to it, and writes the 4-bit sum into one destination (A, B, the output register or the program counter). A register-to-register move is therefore a move only when its immediate is zero. A jump is a write into the program counter through the same adder. The program image is a parameter of the top module, so one core can be built around any 16-word program.

Top module: `imm4_core`

## Requirements
- R1: When `rst` is high at a rising edge, A, B, the carry flag, the program counter and the output register all become 0. After that edge `pc_o` and `out_port` read 0.
- R2: An instruction that does not load the program counter advances it by one, and the count wraps from 15 to 0.
- R3: The instruction word has the immediate in bits [7:4] and the opcode in bits [3:0]. The register opcodes write (source + immediate) mod 16: 0000 A←A, 0101 B←B, 0011 A←zero, 0111 B←zero, 0001 A←B, 0100 B←A. A move with a non-zero immediate adds that immediate.
- R4: Every instruction, including jumps and no-ops, loads the carry flag with the carry out of its own 4-bit addition. For a zero source that carry is 0.
- R5: Opcode 1111 loads the program counter with the immediate, whatever the carry flag holds.
- R6: Opcode 1110 loads the program counter with the immediate when the carry flag left by the previous instruction is 0. When that flag is 1, the program counter advances by one instead.
- R7: Opcode 1001 loads the output register with B + immediate, and opcode 1011 loads it with the immediate alone. No other opcode changes the output register.
- R8: Opcode 0010 loads A with input + immediate, and opcode 0110 loads B with input + immediate. The input port is the value present at the executing edge.
- R9: Opcodes 1000, 1010, 1100 and 1101 leave A, B and the output register unchanged, and only advance the program counter.
- R10: Each instruction completes in one clock cycle, with all state updated on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 4 | Input port, used as an adder source |
| out_port | output | 4 | Output register |
| pc_o | output | 4 | Current program counter (address of the instruction being executed) |

## Verification
The conditional jump reads the carry flag left by the previous instruction. In the same edge, the jump's own zero-source addition overwrites that flag. A design that tests the new carry, or that skips the carry update on jumps, therefore takes the wrong branch. The test program puts an input-dependent addition directly in front of a conditional jump and randomises the input port, so both the taken and the fall-through paths occur many times. The taken path also lands on the last ROM word, so the 15-to-0 wrap follows it. A behavioural model steps the same program in parallel, and the program counter and output register are compared against it after every edge.

// File: rtl/imm4_pkg.sv
package imm4_pkg;

    localparam int NIB       = 4;
    localparam int WORD_W    = 2 * NIB;
    localparam int ROM_DEPTH = 1 << NIB;

    typedef logic [NIB-1:0]    nib_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        nib_t imm;
        nib_t op;
    } instr_t;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_IN   = 2'd2,
        SRC_ZERO = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_A    = 3'd1,
        DST_B    = 3'd2,
        DST_OUT  = 3'd3,
        DST_PC   = 3'd4
    } dst_e;

    typedef struct packed {
        src_e src;
        dst_e dst;
        logic cond;
    } ctrl_t;

    typedef struct packed {
        logic a;
        logic b;
        logic out;
        logic pc;
    } load_t;

    localparam nib_t OP_ADD_A  = 4'b0000;
    localparam nib_t OP_MOV_AB = 4'b0001;
    localparam nib_t OP_IN_A   = 4'b0010;
    localparam nib_t OP_LDI_A  = 4'b0011;
    localparam nib_t OP_MOV_BA = 4'b0100;
    localparam nib_t OP_ADD_B  = 4'b0101;
    localparam nib_t OP_IN_B   = 4'b0110;
    localparam nib_t OP_LDI_B  = 4'b0111;
    localparam nib_t OP_OUT_B  = 4'b1001;
    localparam nib_t OP_OUT_I  = 4'b1011;
    localparam nib_t OP_JNC    = 4'b1110;
    localparam nib_t OP_JMP    = 4'b1111;

    function automatic ctrl_t decode_op(nib_t op);
        ctrl_t c;
        c.src  = SRC_ZERO;
        c.dst  = DST_NONE;
        c.cond = 1'b0;
        case (op)
            OP_ADD_A:  begin c.src = SRC_A;    c.dst = DST_A;   end
            OP_MOV_AB: begin c.src = SRC_B;    c.dst = DST_A;   end
            OP_IN_A:   begin c.src = SRC_IN;   c.dst = DST_A;   end
            OP_LDI_A:  begin c.src = SRC_ZERO; c.dst = DST_A;   end
            OP_MOV_BA: begin c.src = SRC_A;    c.dst = DST_B;   end
            OP_ADD_B:  begin c.src = SRC_B;    c.dst = DST_B;   end
            OP_IN_B:   begin c.src = SRC_IN;   c.dst = DST_B;   end
            OP_LDI_B:  begin c.src = SRC_ZERO; c.dst = DST_B;   end
            OP_OUT_B:  begin c.src = SRC_B;    c.dst = DST_OUT; end
            OP_OUT_I:  begin c.src = SRC_ZERO; c.dst = DST_OUT; end
            OP_JMP:    begin c.src = SRC_ZERO; c.dst = DST_PC;  end
            OP_JNC:    begin c.src = SRC_ZERO; c.dst = DST_PC; c.cond = 1'b1; end
            default:   begin c.src = SRC_ZERO; c.dst = DST_NONE; end
        endcase
        return c;
    endfunction

    function automatic word_t make_word(nib_t imm, nib_t op);
        instr_t w;
        w.imm = imm;
        w.op  = op;
        return w;
    endfunction

endpackage

// File: rtl/imm4_rom.sv
module imm4_rom
    import imm4_pkg::*;
#(
    parameter int DEPTH = ROM_DEPTH,
    parameter logic [WORD_W*DEPTH-1:0] IMAGE = '0
) (
    input  logic [$clog2(DEPTH)-1:0] addr,
    output word_t                    word
);

    word_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign mem[i] = IMAGE[WORD_W*i +: WORD_W];
    end

    assign word = mem[addr];

endmodule

// File: rtl/imm4_decode.sv
module imm4_decode
    import imm4_pkg::*;
(
    input  nib_t  op,
    input  logic  carry,
    output src_e  src,
    output load_t load
);

    ctrl_t ctrl;

    always_comb begin
        ctrl     = decode_op(op);
        src      = ctrl.src;
        load.a   = (ctrl.dst == DST_A);
        load.b   = (ctrl.dst == DST_B);
        load.out = (ctrl.dst == DST_OUT);
        // a conditional jump fires only while the stored carry is clear
        load.pc  = (ctrl.dst == DST_PC) && !(ctrl.cond && carry);
    end

endmodule

// File: rtl/imm4_adder.sv
module imm4_adder
    import imm4_pkg::*;
#(
    parameter bit RIPPLE = 1'b1
) (
    input  src_e sel,
    input  nib_t a,
    input  nib_t b,
    input  nib_t in_val,
    input  nib_t imm,
    output nib_t sum,
    output logic cout
);

    nib_t opnd;

    always_comb begin
        case (sel)
            SRC_A:   opnd = a;
            SRC_B:   opnd = b;
            SRC_IN:  opnd = in_val;
            default: opnd = '0;
        endcase
    end

    if (RIPPLE) begin : g_ripple
        logic [NIB:0] cy;
        assign cy[0] = 1'b0;
        for (genvar i = 0; i < NIB; i++) begin : g_bit
            assign sum[i]  = opnd[i] ^ imm[i] ^ cy[i];
            assign cy[i+1] = (opnd[i] & imm[i]) | (cy[i] & (opnd[i] ^ imm[i]));
        end
        assign cout = cy[NIB];
    end else begin : g_behav
        logic [NIB:0] wide;
        assign wide = {1'b0, opnd} + {1'b0, imm};
        assign sum  = wide[NIB-1:0];
        assign cout = wide[NIB];
    end

endmodule

// File: rtl/imm4_core.sv
module imm4_core
    import imm4_pkg::*;
#(
    parameter logic [WORD_W*ROM_DEPTH-1:0] PROGRAM = '0,
    parameter bit RIPPLE_ADD = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] in_port,
    output logic [3:0] out_port,
    output logic [3:0] pc_o
);

    nib_t   pc_q, a_q, b_q, out_q;
    logic   c_q;
    word_t  word;
    instr_t ins;
    src_e   src;
    load_t  load;
    nib_t   sum;
    logic   cout;

    imm4_rom #(
        .DEPTH (ROM_DEPTH),
        .IMAGE (PROGRAM)
    ) u_rom (
        .addr (pc_q),
        .word (word)
    );

    assign ins = instr_t'(word);

    imm4_decode u_dec (
        .op    (ins.op),
        .carry (c_q),
        .src   (src),
        .load  (load)
    );

    imm4_adder #(
        .RIPPLE (RIPPLE_ADD)
    ) u_add (
        .sel    (src),
        .a      (a_q),
        .b      (b_q),
        .in_val (in_port),
        .imm    (ins.imm),
        .sum    (sum),
        .cout   (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            out_q <= '0;
            c_q   <= 1'b0;
        end else begin
            c_q  <= cout;
            pc_q <= load.pc ? sum : pc_q + 1'b1;
            if (load.a)   a_q   <= sum;
            if (load.b)   b_q   <= sum;
            if (load.out) out_q <= sum;
        end
    end

    assign out_port = out_q;
    assign pc_o     = pc_q;

endmodule

// File: rtl/imm4_chk.sv
module imm4_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] pc,
    input logic [3:0] out_val,
    input logic [3:0] a,
    input logic [3:0] b,
    input logic       carry,
    input logic [7:0] word
);

    logic rst_d = 1'b0;
    logic armed = 1'b0;
    logic [3:0] op;
    logic [3:0] imm;
    logic       unmapped;
    logic       writes_out;

    assign op  = word[3:0];
    assign imm = word[7:4];
    assign unmapped   = (op == 4'b1000) || (op == 4'b1010) ||
                        (op == 4'b1100) || (op == 4'b1101);
    assign writes_out = (op == 4'b1001) || (op == 4'b1011);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) armed <= 1'b1;
        if (rst_d) begin
            a_r1_reset_clear: assert (pc == 4'd0 && out_val == 4'd0 &&
                                      a == 4'd0 && b == 4'd0 && !carry)
                else $error("R1 state not cleared after reset");
        end
    end

    a_r5_jmp_target: assert property (@(posedge clk) disable iff (rst || !armed)
        (op == 4'b1111) |=> (pc == $past(imm)));

    a_r6_jnc_fallthrough: assert property (@(posedge clk) disable iff (rst || !armed)
        (op == 4'b1110 && carry) |=> (pc == $past(pc) + 4'd1));

    a_r6_jnc_taken: assert property (@(posedge clk) disable iff (rst || !armed)
        (op == 4'b1110 && !carry) |=> (pc == $past(imm)));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst || !armed)
        (op != 4'b1110 && op != 4'b1111) |=> (pc == $past(pc) + 4'd1));

    a_r4_jump_clears_carry: assert property (@(posedge clk) disable iff (rst || !armed)
        (op == 4'b1110 || op == 4'b1111) |=> !carry);

    a_r7_out_hold: assert property (@(posedge clk) disable iff (rst || !armed)
        !writes_out |=> $stable(out_val));

    a_r9_nop_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
        unmapped |=> ($stable(a) && $stable(b) && $stable(out_val)));

endmodule

bind imm4_core imm4_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc_q),
    .out_val (out_q),
    .a       (a_q),
    .b       (b_q),
    .carry   (c_q),
    .word    (word)
);

// File: tb/imm4_core_tb.sv
module imm4_core_tb;

    // word i sits at bits [8*i +: 8]; listed from word 15 down to word 0
    localparam logic [127:0] PROG = {
        8'hAB, 8'h6F, 8'hFE, 8'h42, 8'hC5, 8'h67, 8'h12, 8'hF1,
        8'h58, 8'h19, 8'h24, 8'h09, 8'h36, 8'h0E, 8'h80, 8'h93
    };
    localparam int RUN_CYCLES = 3000;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_port = 4'd0;
    logic [3:0] out_port;
    logic [3:0] pc_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    imm4_core #(.PROGRAM(PROG)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_port  (in_port),
        .out_port (out_port),
        .pc_o     (pc_o)
    );

    always #2 clk = ~clk;

    // reference state
    int m_a = 0, m_b = 0, m_out = 0, m_pc = 0, m_c = 0;
    string pc_tag = "R1";
    string out_tag = "R1";

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(bit r, int inp);
        int w, imm, op, s, nxt;
        if (r) begin
            m_a = 0; m_b = 0; m_out = 0; m_pc = 0; m_c = 0;
            pc_tag = "R1"; out_tag = "R1";
            return;
        end
        w   = int'(PROG[8*m_pc +: 8]);
        imm = w / 16;
        op  = w % 16;
        nxt = (m_pc + 1) % 16;
        pc_tag  = "R2/R10";
        out_tag = "R7";
        case (op)
            0:  begin s = m_a + imm; m_a = s % 16; end
            5:  begin s = m_b + imm; m_b = s % 16; end
            3:  begin s = imm;       m_a = s;      end
            7:  begin s = imm;       m_b = s;      end
            1:  begin s = m_b + imm; m_a = s % 16; end
            4:  begin s = m_a + imm; m_b = s % 16; end
            2:  begin s = inp + imm; m_a = s % 16; end
            6:  begin s = inp + imm; m_b = s % 16; end
            9:  begin s = m_b + imm; m_out = s % 16; out_tag = "R3/R7/R8"; end
            11: begin s = imm;       m_out = s;      out_tag = "R7"; end
            15: begin s = imm; nxt = imm; pc_tag = "R5/R10"; end
            14: begin
                    s = imm;
                    if (m_c == 0) nxt = imm;
                    pc_tag = "R4/R6";
                end
            default: begin s = imm; out_tag = "R9"; end
        endcase
        m_c  = (s > 15) ? 1 : 0;
        m_pc = nxt;
    endtask

    initial begin
        bit r;
        int v;
        // first edge sees reset
        model_step(1'b1, 0);
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            @(negedge clk);
            if (cyc > 0) begin
                check(pc_tag, "pc", int'(pc_o), m_pc);
                check(out_tag, "out", int'(out_port), m_out);
            end
            r = (cyc < 2) || (cyc >= 1500 && cyc < 1502);
            v = int'($urandom_range(0, 15));
            rst = r;
            in_port = 4'(v);
            model_step(r, v);
        end
        @(negedge clk);
        check(pc_tag, "pc", int'(pc_o), m_pc);
        check(out_tag, "out", int'(out_port), m_out);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, RUN_CYCLES);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule